// File: doc/BRIEF.md
# One-Way Device Lifecycle Gate

This block holds the life stage of a secure device and decides, cycle by cycle, whether each host command is allowed to run. The stage moves through four values in a fixed forward order: factory, provisioned, locked, and returned-for-analysis. No request can bring it back to an earlier stage, and it can never skip a stage.

A command decoder upstream presents an opcode with a valid strobe. One cycle later the block answers with exactly one of permit or reject. The same decoder may also request a move to a target stage. A legal move takes effect on the next clock edge. A refused request, whether it is a stage move or a command, leaves the stage unchanged and raises a one-cycle error pulse with a reason code.

There is no non-volatile storage in this block. While reset is held, the stage is loaded from a stored image word on an input port. The image carries the stage code together with its bitwise inverse, so a damaged image can be detected. A damaged image sends the device to its terminal stage.

Top module: `lcm_top`

## Requirements
- R1: The stage is a 2-bit code with the forward order 00 factory, 01 provisioned, 10 locked, 11 returned; this code is presented on `state_o`.
- R2: While `rst_n` is low at a clock edge, the stage is loaded from `boot_image_i`. Bits [1:0] hold the code and bits [3:2] must equal the bitwise inverse of bits [1:0]. A consistent image loads its code, and during reset all response outputs are 0.
- R3: An image whose bits [3:2] are not the inverse of bits [1:0] loads stage 11.
- R4: An advance request whose target equals the current stage plus one updates `state_o` on the next edge. The stage never changes for any other reason.
- R5: An advance request whose target is less than or equal to the current stage is refused with reason 1. The stage never decreases, and stage 11 accepts no move.
- R6: An advance request whose target is more than one step ahead is refused with reason 2, and the stage is kept.
- R7: Key provisioning (opcode 1) is permitted only in stages 00 and 01.
- R8: Signing (opcode 2), decapsulation (opcode 3) and channel open (opcode 4) are permitted only in stages 01 and 10.
- R9: Status read (opcode 0) is permitted in every stage. In stage 11 it is the only command permitted.
- R10: A known opcode that is not allowed in the current stage is rejected with reason 3. Opcodes 5 to 7 are rejected in every stage with reason 4.
- R11: Each refused event raises `err_pulse_o` for one cycle, with `err_code_o` nonzero; otherwise `err_code_o` is 0. If a move and a command are both refused in the same cycle, the move's reason is reported. A command is judged against the stage held before any move requested in the same cycle.
- R12: For every cycle with `cmd_valid_i` high, exactly one of `cmd_permit_o` and `cmd_reject_o` is high in the following cycle; both stay low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the stored stage |
| boot_image_i | input | 4 | Stored stage image: code in [1:0], inverse in [3:2] |
| adv_req_i | input | 1 | Request to advance the stage |
| adv_target_i | input | 2 | Requested target stage code |
| cmd_valid_i | input | 1 | Host command opcode valid |
| cmd_op_i | input | 3 | Host command opcode |
| state_o | output | 2 | Current stage code |
| cmd_permit_o | output | 1 | Previous-cycle command permitted |
| cmd_reject_o | output | 1 | Previous-cycle command rejected |
| err_pulse_o | output | 1 | One-cycle refusal indication |
| err_code_o | output | 3 | Refusal reason: 1 backward, 2 skip, 3 denied, 4 unknown |

## Verification
A corrupted stage register shows up directly on `state_o` one edge later. It also shows up indirectly in the permit pattern of the next command, because the same opcode gets a different verdict in a different stage. An error in the legality or priority logic shows up as a wrong reason code or as a stage that stays put or moves, one cycle after the request. For this reason the stimulus issues each opcode in every stage, including same-cycle moves and commands, so that a wrong stage or a wrong table entry produces a visible difference within one cycle.

// File: rtl/lcm_pkg.sv
// Shared definitions for the lifecycle gate: stage codes, reason codes,
// opcode values and the per-opcode permission function.
// Assumes a 2-bit stage code whose numeric order is the life order.
package lcm_pkg;

    localparam int ST_W  = 2;
    localparam int IMG_W = 2 * ST_W;
    localparam int RSN_W = 3;
    localparam int NUM_STATES = 1 << ST_W;

    typedef enum logic [ST_W-1:0] {
        LC_FACTORY = 2'b00,
        LC_PROV    = 2'b01,
        LC_LOCKED  = 2'b10,
        LC_RETURN  = 2'b11
    } lc_state_e;

    typedef enum logic [RSN_W-1:0] {
        RSN_NONE     = 3'd0,
        RSN_BACKWARD = 3'd1,
        RSN_SKIP     = 3'd2,
        RSN_DENIED   = 3'd3,
        RSN_UNKNOWN  = 3'd4
    } rsn_e;

    localparam int OP_STATUS  = 0;
    localparam int OP_KEYPROV = 1;
    localparam int OP_SIGN    = 2;
    localparam int OP_DECAP   = 3;
    localparam int OP_CHOPEN  = 4;
    localparam int NUM_KNOWN_OPS = 5;

    // Bit s of the result is set when the opcode may run in stage s.
    function automatic logic [NUM_STATES-1:0] op_allow_mask(input int op);
        case (op)
            OP_STATUS:                     return 4'b1111;
            OP_KEYPROV:                    return 4'b0011;
            OP_SIGN, OP_DECAP, OP_CHOPEN:  return 4'b0110;
            default:                       return 4'b0000;
        endcase
    endfunction

    // Returns the stored code when its inverse copy matches, else the terminal stage.
    function automatic lc_state_e decode_image(input logic [IMG_W-1:0] img);
        if (img[IMG_W-1:ST_W] == ~img[ST_W-1:0])
            return lc_state_e'(img[ST_W-1:0]);
        return LC_RETURN;
    endfunction

endpackage

// File: rtl/lcm_state_reg.sv
// Stage register with forward-only, single-step transition legality.
// Assumes the stage image is stable while rst_n is low.
// Produces a combinational refusal reason for the same cycle's request.
module lcm_state_reg
    import lcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IMG_W-1:0] boot_image_i,
    input  logic             adv_req_i,
    input  logic [ST_W-1:0]  adv_target_i,
    output lc_state_e        state_o,
    output rsn_e             adv_rsn_o
);

    logic [ST_W-1:0] next_code;
    logic            adv_ok;

    // Work out whether the request names exactly the following stage.
    always_comb begin
        next_code = state_o + ST_W'(1);
        adv_ok    = adv_req_i && (state_o != LC_RETURN) && (adv_target_i == next_code);
        if (!adv_req_i || adv_ok)
            adv_rsn_o = RSN_NONE;
        else if (adv_target_i <= state_o)
            adv_rsn_o = RSN_BACKWARD;
        else
            adv_rsn_o = RSN_SKIP;
    end

    // Load the stored stage in reset, otherwise step forward on a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_o <= decode_image(boot_image_i);
        else if (adv_ok)
            state_o <= lc_state_e'(adv_target_i);
    end

endmodule

// File: rtl/lcm_cmd_gate.sv
// Combinational command gate: looks up the opcode in a permission table
// built per opcode from the package function, indexed by the current stage.
// Assumes opcodes at or above NUM_KNOWN_OPS are undefined.
module lcm_cmd_gate
    import lcm_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  lc_state_e       state_i,
    input  logic            cmd_valid_i,
    input  logic [OP_W-1:0] cmd_op_i,
    output logic            permit_o,
    output logic            reject_o,
    output rsn_e            cmd_rsn_o
);

    localparam int NUM_OPS = 1 << OP_W;

    logic [NUM_STATES-1:0] allow_tbl [NUM_OPS];
    logic                  known_tbl [NUM_OPS];

    // One table row per opcode value.
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        assign allow_tbl[i] = op_allow_mask(i);
        assign known_tbl[i] = (i < NUM_KNOWN_OPS);
    end

    // Pick the verdict and reason for the presented opcode.
    always_comb begin
        permit_o  = 1'b0;
        reject_o  = 1'b0;
        cmd_rsn_o = RSN_NONE;
        if (cmd_valid_i) begin
            if (!known_tbl[cmd_op_i]) begin
                reject_o  = 1'b1;
                cmd_rsn_o = RSN_UNKNOWN;
            end else if (!allow_tbl[cmd_op_i][state_i]) begin
                reject_o  = 1'b1;
                cmd_rsn_o = RSN_DENIED;
            end else begin
                permit_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcm_resp_reg.sv
// Registers the command verdict and merges the two refusal sources into
// one error pulse. A stage-move refusal takes priority over a command one.
module lcm_resp_reg
    import lcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic permit_i,
    input  logic reject_i,
    input  rsn_e adv_rsn_i,
    input  rsn_e cmd_rsn_i,
    output logic permit_o,
    output logic reject_o,
    output logic err_pulse_o,
    output rsn_e err_code_o
);

    rsn_e sel_rsn;

    // Choose the reason to report this cycle.
    always_comb begin
        sel_rsn = (adv_rsn_i != RSN_NONE) ? adv_rsn_i : cmd_rsn_i;
    end

    // Hold the verdict and the error for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            permit_o    <= 1'b0;
            reject_o    <= 1'b0;
            err_pulse_o <= 1'b0;
            err_code_o  <= RSN_NONE;
        end else begin
            permit_o    <= permit_i;
            reject_o    <= reject_i;
            err_pulse_o <= (sel_rsn != RSN_NONE);
            err_code_o  <= sel_rsn;
        end
    end

endmodule

// File: rtl/lcm_top.sv
// Lifecycle gate top: stage register, command gate and response register.
// Commands are judged against the stage held before a same-cycle move.
module lcm_top
    import lcm_pkg::*;
#(
    parameter int OP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IMG_W-1:0] boot_image_i,
    input  logic             adv_req_i,
    input  logic [ST_W-1:0]  adv_target_i,
    input  logic             cmd_valid_i,
    input  logic [OP_W-1:0]  cmd_op_i,
    output logic [ST_W-1:0]  state_o,
    output logic             cmd_permit_o,
    output logic             cmd_reject_o,
    output logic             err_pulse_o,
    output logic [RSN_W-1:0] err_code_o
);

    lc_state_e cur_state;
    rsn_e      adv_rsn;
    rsn_e      cmd_rsn;
    rsn_e      err_code;
    logic      permit_c;
    logic      reject_c;

    lcm_state_reg u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_image_i (boot_image_i),
        .adv_req_i    (adv_req_i),
        .adv_target_i (adv_target_i),
        .state_o      (cur_state),
        .adv_rsn_o    (adv_rsn)
    );

    lcm_cmd_gate #(.OP_W(OP_W)) u_gate (
        .state_i     (cur_state),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .permit_o    (permit_c),
        .reject_o    (reject_c),
        .cmd_rsn_o   (cmd_rsn)
    );

    lcm_resp_reg u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .permit_i    (permit_c),
        .reject_i    (reject_c),
        .adv_rsn_i   (adv_rsn),
        .cmd_rsn_i   (cmd_rsn),
        .permit_o    (cmd_permit_o),
        .reject_o    (cmd_reject_o),
        .err_pulse_o (err_pulse_o),
        .err_code_o  (err_code)
    );

    assign state_o    = cur_state;
    assign err_code_o = err_code;

endmodule

// File: rtl/lcm_checks.sv
// Port-level properties of the lifecycle gate, attached by bind.
module lcm_checks
    import lcm_pkg::*;
#(
    parameter int OP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_req_i,
    input logic [ST_W-1:0]  adv_target_i,
    input logic             cmd_valid_i,
    input logic [OP_W-1:0]  cmd_op_i,
    input logic [ST_W-1:0]  state_o,
    input logic             cmd_permit_o,
    input logic             cmd_reject_o,
    input logic             err_pulse_o,
    input logic [RSN_W-1:0] err_code_o
);

    assert_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_o >= $past(state_o));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_o != $past(state_o)) |->
        (state_o == $past(state_o) + 2'd1 && $past(adv_req_i) && $past(adv_target_i) == state_o));

    assert_exclusive_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_permit_o && cmd_reject_o));

    assert_verdict_follows_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cmd_permit_o || cmd_reject_o) == $past(cmd_valid_i)));

    assert_status_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_valid_i) && $past(cmd_op_i) == OP_W'(OP_STATUS)) |-> cmd_permit_o);

    assert_return_status_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_o) == LC_RETURN && cmd_permit_o) |->
        $past(cmd_op_i) == OP_W'(OP_STATUS));

    assert_err_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o == (err_code_o != RSN_NONE));

    assert_reject_flags_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject_o |-> err_pulse_o);

endmodule

bind lcm_top lcm_checks #(.OP_W(OP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv_req_i    (adv_req_i),
    .adv_target_i (adv_target_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .state_o      (state_o),
    .cmd_permit_o (cmd_permit_o),
    .cmd_reject_o (cmd_reject_o),
    .err_pulse_o  (err_pulse_o),
    .err_code_o   (err_code_o)
);

// File: tb/sim_lcm_top.sv
// Scoreboard bench: the driver computes the expected response of each
// cycle from the requirements and queues it; the monitor compares after each edge.
module sim_lcm_top;

    typedef struct {
        logic [1:0] st;
        logic       pm;
        logic       rj;
        logic       ep;
        logic [2:0] ec;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] boot_image = 4'b1100;
    logic       adv_req = 1'b0;
    logic [1:0] adv_tgt = 2'b00;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] state;
    logic       permit, reject, err_pulse;
    logic [2:0] err_code;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    logic [1:0] m_state = 2'b00;

    lcm_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_image_i (boot_image),
        .adv_req_i    (adv_req),
        .adv_target_i (adv_tgt),
        .cmd_valid_i  (cmd_valid),
        .cmd_op_i     (cmd_op),
        .state_o      (state),
        .cmd_permit_o (permit),
        .cmd_reject_o (reject),
        .err_pulse_o  (err_pulse),
        .err_code_o   (err_code)
    );

    always #10 clk = ~clk;

    // Bench's own view of which stages allow an opcode (R7, R8, R9).
    function automatic bit allowed(input logic [2:0] op, input logic [1:0] s);
        case (op)
            3'd0:             return 1'b1;
            3'd1:             return (s == 2'b00) || (s == 2'b01);
            3'd2, 3'd3, 3'd4: return (s == 2'b01) || (s == 2'b10);
            default:          return 1'b0;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and queue its expected outcome.
    task automatic step(input logic adv, input logic [1:0] tgt, input logic cv,
                        input logic [2:0] op, input string req);
        exp_t e;
        logic [2:0] a_rsn, c_rsn;
        bit legal;
        @(negedge clk);
        adv_req = adv; adv_tgt = tgt; cmd_valid = cv; cmd_op = op;
        legal = adv && (m_state != 2'b11) && (tgt == m_state + 2'd1);
        a_rsn = (!adv || legal) ? 3'd0 : ((tgt <= m_state) ? 3'd1 : 3'd2);
        c_rsn = !cv ? 3'd0 : (op > 3'd4) ? 3'd4 : !allowed(op, m_state) ? 3'd3 : 3'd0;
        e.pm  = cv && (c_rsn == 3'd0);
        e.rj  = cv && (c_rsn != 3'd0);
        e.ec  = (a_rsn != 3'd0) ? a_rsn : c_rsn;
        e.ep  = (e.ec != 3'd0);
        if (legal) m_state = tgt;
        e.st  = m_state;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // Hold reset for one edge with a given stored image, then release.
    task automatic do_reset(input logic [3:0] img, input string req);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; boot_image = img;
        adv_req = 1'b0; cmd_valid = 1'b0;
        m_state = (img[3:2] == ~img[1:0]) ? img[1:0] : 2'b11;
        e.st = m_state; e.pm = 0; e.rj = 0; e.ep = 0; e.ec = 0; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare outputs shortly after each edge against the queued item.
    always @(posedge clk) begin
        exp_t e;
        #3;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (state !== e.st || permit !== e.pm || reject !== e.rj ||
                err_pulse !== e.ep || err_code !== e.ec) begin
                failures++;
                $display("FAIL %s: got st=%b pm=%b rj=%b ep=%b ec=%0d, want st=%b pm=%b rj=%b ep=%b ec=%0d",
                         e.req, state, permit, reject, err_pulse, err_code,
                         e.st, e.pm, e.rj, e.ep, e.ec);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hang, want completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(4'b1100, "R2 factory image");
        step(0, 2'b00, 1, 3'd0, "R9 status in factory");
        step(0, 2'b00, 1, 3'd1, "R7 keyprov in factory");
        step(0, 2'b00, 1, 3'd2, "R8 sign denied in factory");
        step(0, 2'b00, 1, 3'd6, "R10 unknown opcode");
        step(0, 2'b00, 1, 3'd4, "R10 chopen denied reason");
        step(1, 2'b10, 0, 3'd0, "R6 skip to locked");
        step(1, 2'b11, 0, 3'd0, "R6 skip to returned");
        step(1, 2'b00, 0, 3'd0, "R5 equal target");
        step(0, 2'b00, 0, 3'd0, "R11 idle no error");
        step(1, 2'b01, 0, 3'd0, "R4 advance to provisioned");
        step(0, 2'b00, 1, 3'd2, "R8 sign in provisioned");
        step(0, 2'b00, 1, 3'd3, "R8 decap in provisioned");
        step(0, 2'b00, 1, 3'd4, "R8 chopen in provisioned");
        step(0, 2'b00, 1, 3'd7, "R10 unknown in provisioned");
        step(1, 2'b10, 1, 3'd1, "R11 cmd judged on old stage");
        step(0, 2'b00, 1, 3'd1, "R7 keyprov denied in locked");
        step(0, 2'b00, 1, 3'd3, "R8 decap in locked");
        step(1, 2'b00, 1, 3'd5, "R11 move reason wins");
        step(1, 2'b01, 0, 3'd0, "R5 backward from locked");
        step(1, 2'b11, 0, 3'd0, "R4 advance to returned");
        step(0, 2'b00, 1, 3'd0, "R9 status in returned");
        step(0, 2'b00, 1, 3'd2, "R9 sign denied in returned");
        step(0, 2'b00, 1, 3'd1, "R9 keyprov denied in returned");
        step(1, 2'b11, 0, 3'd0, "R5 returned is terminal");
        step(1, 2'b00, 0, 3'd0, "R5 returned refuses wrap");
        step(0, 2'b00, 0, 3'd0, "R1 stage held at 11");
        do_reset(4'b1001, "R2 provisioned image");
        step(0, 2'b00, 1, 3'd3, "R2 decap after provisioned load");
        do_reset(4'b0110, "R2 locked image");
        step(0, 2'b00, 1, 3'd1, "R7 keyprov after locked load");
        do_reset(4'b0000, "R3 corrupt image 0000");
        step(0, 2'b00, 1, 3'd2, "R3 sign denied after corrupt load");
        do_reset(4'b1110, "R3 corrupt image 1110");
        do_reset(4'b0011, "R2 returned image");
        do_reset(4'b1100, "R1 back to factory code 00");
        step(1, 2'b01, 1, 3'd1, "R4 advance with keyprov");
        step(1, 2'b10, 0, 3'd0, "R4 advance to locked code 10");
        step(0, 2'b00, 0, 3'd0, "R12 no verdict without valid");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule